// File: doc/BRIEF.md
# Lane Scrambler / Descrambler (1 + x^14 + x^15)

This block whitens one 32-bit lane word per clock ahead of line coding on a multi-lane converter serial link, and undoes that whitening on the receive side after line decoding. The word is four octets. It is treated as a serial stream sent most significant bit first: octet 3 bit 7 leads and octet 0 bit 0 trails. Each scrambled bit is the data bit XORed with the scrambled bits 14 and 15 places earlier in that stream. All 32 bits of a word are resolved in one clock from a 15-bit history of past stream bits.

A single module covers both directions, and a parameter selects which one it is. The descrambler applies the same XOR, but to the bits it receives, so it locks to the stream by itself. No seed is exchanged and no handshake is needed. A line error therefore spoils only a short, bounded stretch of output. Each lane of the link carries its own instance. A bypass control lets data through unaltered with the same timing. The history follows the stream whenever a valid word goes by and is frozen between valid words.

Top module: `lane_scrambler`

## Requirements
- R1: While synchronous reset is high, the output word and output valid are zero at the next clock. The 15-bit history is cleared, so the first word after reset is processed as if the 15 preceding stream bits were all zero.
- R2: In scrambling mode with enable high, each output bit is the input bit XOR the output-stream bits 14 and 15 positions earlier. Bits are ordered in the serial stream from bit 31 (first) down to bit 0 (last). Example: from a cleared history, input 0x80000000 gives 0x8003000A.
- R3: Output valid equals input valid delayed by exactly one clock. A valid output word appears in the clock after its input word.
- R4: When input valid is low, the history and the output word hold their values, and the idle cycle has no effect on the processing of later words.
- R5: With enable low, the output word equals the input word one clock later. The history keeps tracking the stream (the output stream in scrambling mode, the received stream in descrambling mode), so later scrambled words follow on from the bypassed bits.
- R6: In descrambling mode with enable high, each output bit is the received bit XOR the received bits 14 and 15 positions earlier. A scrambler feeding a descrambler therefore returns the original words, two clocks after input.
- R7: After bit errors on the line, descrambler output is correct from the 16th correct bit after the last error onward. A single flipped bit at position 16 of a word corrupts output bits 16, 2 and 1 of that word and nothing later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scr_en | input | 1 | 1 = scramble or descramble, 0 = bypass |
| din_vld | input | 1 | Input word valid |
| din | input | 32 | Input word, bit 31 first in serial order |
| dout_vld | output | 1 | Output word valid, one clock after din_vld |
| dout | output | 32 | Output word |

## Verification
Random words on a scrambler chained into a descrambler show that the transforms are inverse across word boundaries. A single leading one from a cleared history yields a known sparse pattern, which pins the tap distances and the bit order. Valid strobes with gaps separate history that is gated by valid from history that runs freely, and runs that toggle bypass check that the history tracks the stream while bypassed. A single-bit line error and a whole-word line error, each injected between the two instances, show that the error stays confined to the expected output bits and that the output fully recovers by the second word after the error.

// File: rtl/lane_scrambler.sv
module lane_scrambler #(
  parameter int W          = 32,
  parameter int TAP_NEAR   = 14,
  parameter int TAP_FAR    = 15,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scr_en,
  input  logic         din_vld,
  input  logic [W-1:0] din,
  output logic         dout_vld,
  output logic [W-1:0] dout
);
  localparam int HW = TAP_FAR;
  localparam int EW = W + HW;

  logic [HW-1:0] hist;
  logic [HW-1:0] hist_nxt;
  logic [W-1:0]  res;

  always_comb begin
    logic [EW-1:0] e;
    logic          fb;
    e = {hist, {W{1'b0}}};
    res = '0;
    for (int j = W - 1; j >= 0; j--) begin
      fb = e[j+TAP_NEAR] ^ e[j+TAP_FAR];
      res[j] = scr_en ? (din[j] ^ fb) : din[j];
      e[j] = DESCRAMBLE ? din[j] : res[j];
    end
    hist_nxt = e[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= din_vld;
      if (din_vld) begin
        hist <= hist_nxt;
        dout <= res;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dout_vld == 1'b0 && dout == '0 && hist == '0));

  p_vld_follows_r3: assert property (@(posedge clk) disable iff (rst)
    din_vld |=> dout_vld);

  p_vld_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> !dout_vld);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> ($stable(hist) && $stable(dout)));

  p_bypass_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !scr_en) |=> (dout == $past(din)));

  generate
    if (DESCRAMBLE) begin : g_rx_chk
      p_hist_rx_stream_r6: assert property (@(posedge clk) disable iff (rst)
        din_vld |=> (hist == $past(din[HW-1:0])));
    end else begin : g_tx_chk
      p_hist_tx_stream_r2: assert property (@(posedge clk) disable iff (rst)
        din_vld |=> (hist == dout[HW-1:0]));
    end
  endgenerate
endmodule

// File: tb/lane_scrambler_bench.sv
module lane_scrambler_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scr_en = 1'b1;
  logic        din_vld = 1'b0;
  logic [31:0] din = '0;
  logic [31:0] err_mask = '0;
  logic        tx_vld, rx_vld;
  logic [31:0] tx_dout, rx_dout;
  logic [31:0] rx_din;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rx_din = tx_dout ^ err_mask;

  lane_scrambler #(.DESCRAMBLE(1'b0)) u_lane_scrambler (
    .clk(clk), .rst(rst), .scr_en(scr_en), .din_vld(din_vld), .din(din),
    .dout_vld(tx_vld), .dout(tx_dout));

  lane_scrambler #(.DESCRAMBLE(1'b1)) u_lane_scrambler_rx (
    .clk(clk), .rst(rst), .scr_en(scr_en), .din_vld(tx_vld), .din(rx_din),
    .dout_vld(rx_vld), .dout(rx_dout));

  bit          txh[$];
  bit          rxh[$];
  logic [31:0] etx, erx;
  bit          etx_v, erx_v;
  logic [31:0] rxq[$];
  logic [31:0] sentq[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_tx(input logic [31:0] d, input bit en);
    logic [31:0] o;
    bit fb, s;
    for (int j = 31; j >= 0; j--) begin
      fb = txh[txh.size() - 14] ^ txh[txh.size() - 15];
      s = en ? (d[j] ^ fb) : d[j];
      o[j] = s;
      txh.push_back(s);
      void'(txh.pop_front());
    end
    return o;
  endfunction

  function automatic logic [31:0] mdl_rx(input logic [31:0] r, input bit en);
    logic [31:0] o;
    bit fb;
    for (int j = 31; j >= 0; j--) begin
      fb = rxh[rxh.size() - 14] ^ rxh[rxh.size() - 15];
      o[j] = en ? (r[j] ^ fb) : r[j];
      rxh.push_back(r[j]);
      void'(rxh.pop_front());
    end
    return o;
  endfunction

  task automatic step(input logic [31:0] d, input bit v, input bit en, input logic [31:0] m);
    check(tx_vld === etx_v, "R3 scrambler valid", {31'd0, tx_vld}, {31'd0, etx_v});
    check(tx_dout === etx, "R2/R4/R5 scrambler word", tx_dout, etx);
    check(rx_vld === erx_v, "R3 descrambler valid", {31'd0, rx_vld}, {31'd0, erx_v});
    check(rx_dout === erx, "R6/R4 descrambler word", rx_dout, erx);
    if (rx_vld) rxq.push_back(rx_dout);
    if (v) sentq.push_back(d);
    err_mask = m;
    erx_v = etx_v;
    if (etx_v) erx = mdl_rx(etx ^ m, en);
    etx_v = v;
    if (v) etx = mdl_tx(d, en);
    din = d;
    din_vld = v;
    scr_en = en;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din_vld = 1'b0;
    err_mask = '0;
    @(negedge clk);
    @(negedge clk);
    check(tx_vld === 1'b0 && tx_dout === '0, "R1 scrambler reset", tx_dout, 32'd0);
    check(rx_vld === 1'b0 && rx_dout === '0, "R1 descrambler reset", rx_dout, 32'd0);
    txh.delete();
    rxh.delete();
    for (int i = 0; i < 15; i++) begin
      txh.push_back(1'b0);
      rxh.push_back(1'b0);
    end
    etx = '0; erx = '0; etx_v = 1'b0; erx_v = 1'b0;
    rxq.delete();
    sentq.delete();
    rst = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    @(negedge clk);
    do_reset();

    // R1, R2: first word from cleared history
    step(32'h8000_0000, 1'b1, 1'b1, '0);
    check(tx_dout === 32'h8003_000A, "R2 hand value from cleared history (R1)", tx_dout, 32'h8003_000A);
    step('0, 1'b0, 1'b1, '0);
    step('0, 1'b0, 1'b1, '0);

    // R6 chained random traffic with idle gaps (R4)
    do_reset();
    for (int i = 0; i < 60; i++) begin
      w = $urandom;
      step(w, ($urandom % 4) != 0, 1'b1, '0);
    end
    step('0, 1'b0, 1'b1, '0);
    step('0, 1'b0, 1'b1, '0);
    check(rxq.size() == sentq.size(), "R6 word count", rxq.size(), sentq.size());
    for (int k = 0; k < rxq.size() && k < sentq.size(); k++)
      check(rxq[k] === sentq[k], "R6 chained round trip", rxq[k], sentq[k]);

    // R5 bypass
    do_reset();
    for (int i = 0; i < 10; i++) begin
      w = $urandom;
      step(w, 1'b1, 1'b0, '0);
      check(tx_dout === w, "R5 bypass copy", tx_dout, w);
    end
    step('0, 1'b0, 1'b0, '0);
    step('0, 1'b0, 1'b0, '0);
    for (int k = 0; k < rxq.size() && k < sentq.size(); k++)
      check(rxq[k] === sentq[k], "R5 bypass round trip", rxq[k], sentq[k]);
    for (int i = 0; i < 30; i++) begin
      w = $urandom;
      step(w, 1'b1, (i % 3) != 0, '0);
    end
    step('0, 1'b0, 1'b1, '0);
    step('0, 1'b0, 1'b1, '0);

    // R7 single-bit line error at bit 16 of word 2
    do_reset();
    for (int i = 0; i < 6; i++) begin
      w = $urandom;
      step(w, 1'b1, 1'b1, (i == 3) ? 32'h0001_0000 : 32'h0);
    end
    step('0, 1'b0, 1'b1, '0);
    step('0, 1'b0, 1'b1, '0);
    if (rxq.size() >= 6) begin
      check((rxq[2] ^ sentq[2]) === 32'h0001_0006, "R7 single error footprint", rxq[2] ^ sentq[2], 32'h0001_0006);
      check(rxq[3] === sentq[3], "R7 recovered next word", rxq[3], sentq[3]);
      check(rxq[5] === sentq[5], "R7 stays recovered", rxq[5], sentq[5]);
    end else check(1'b0, "R7 missing words", rxq.size(), 32'd6);

    // R7 whole-word line error on word 3
    do_reset();
    for (int i = 0; i < 7; i++) begin
      w = $urandom;
      step(w, 1'b1, 1'b1, (i == 4) ? 32'hFFFF_FFFF : 32'h0);
    end
    step('0, 1'b0, 1'b1, '0);
    step('0, 1'b0, 1'b1, '0);
    if (rxq.size() >= 6) begin
      check(((rxq[4] ^ sentq[4]) & 32'h0001_FFFF) === 32'h0, "R7 tail of next word clean",
            rxq[4] ^ sentq[4], 32'h0);
      check(rxq[5] === sentq[5], "R7 full recovery", rxq[5], sentq[5]);
    end else check(1'b0, "R7 missing words", rxq.size(), 32'd6);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule